// File: doc/BRIEF.md
# Packed Lane Subtractor

This block subtracts one 64-bit packed operand from another, treating both as a row of equal lanes of 8, 16, 32 or 64 bits. An 8-bit operation code picks the lane width and the overflow behaviour. Wraparound keeps the low bits of each difference. Signed saturation clamps each lane to the signed range. Unsigned saturation clamps a negative difference to zero.

A caller presents both operands, the code and the control and feature inputs together with `in_valid`. On the next clock edge the block pulses `out_valid` and raises at most one status flag. If the operation is allowed, the lane-wise difference is written into the destination register `res_q`. If the code is unknown, or the control inputs refuse execution, `res_q` keeps its earlier contents.

Top module: `lane_sub_unit`

## Requirements
- R1: Wraparound codes compute (a - b) mod 2^L in every lane of width L, where lane k occupies bits [k*L+L-1 : k*L]. The codes are F8h (L=8), F9h (L=16), FAh (L=32) and FBh (L=64).
- R2: Signed saturating codes E8h (L=8) and E9h (L=16) treat each lane as a two's complement number. A difference above the largest signed value becomes 7Fh or 7FFFh, and one below the smallest becomes 80h or 8000h.
- R3: Unsigned saturating codes D8h (L=8) and D9h (L=16) give the lane difference when b <= a and give 0 when b > a.
- R4: `res_q`, `out_valid` and the flags are registered. They change on the first rising edge after `in_valid` is sampled high. With `in_valid` low, `out_valid` and every flag are 0 on the next cycle and `res_q` holds.
- R5: Any code other than the eight listed raises `undef_op` alone with `out_valid` and leaves `res_q` unchanged.
- R6: For a listed code, `fault_invalid` is raised and `res_q` is left unchanged when `ctl_emulate` is 1, or when the relevant feature input is 0. The feature input is `feat_wide` for FBh and `feat_base` for every other listed code.
- R7: For a listed code with no `fault_invalid` condition, `ctl_task_sw` = 1 raises `fault_navail` and leaves `res_q` unchanged. `fault_invalid` takes priority over `fault_navail`, so the two are never raised together.
- R8: After reset, `res_q` is 0 and `out_valid`, `undef_op`, `fault_invalid` and `fault_navail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; samples every other input |
| op_code | input | 8 | Operation select |
| src_a | input | 64 | Minuend, packed lanes |
| src_b | input | 64 | Subtrahend, packed lanes |
| ctl_emulate | input | 1 | Control bit that refuses execution |
| ctl_task_sw | input | 1 | Control bit that signals device not available |
| feat_base | input | 1 | Feature present for all codes except FBh |
| feat_wide | input | 1 | Feature present for FBh |
| res_q | output | 64 | Destination register |
| out_valid | output | 1 | Pulse one cycle after an accepted strobe |
| undef_op | output | 1 | Code was not recognised |
| fault_invalid | output | 1 | Execution refused: invalid operation |
| fault_navail | output | 1 | Execution refused: device not available |

## Verification
Directed lane values sit on each side of every clamp point: 7Fh-80h, 80h-01h, 8000h-0001h, 00h-01h and all-ones 64-bit operands. These separate a signed clamp from an unsigned clamp and from a plain wrap, and they show whether a borrow leaks across a lane boundary. Random operands drawn over all eight codes then compare every lane width against a bench model, which catches a width or mode decoded onto the wrong lane slicing. Control and feature inputs are toggled on both the 64-bit code and a narrow code. An unknown code follows each refusal, and a later good operation shows that `res_q` kept the last committed value.

// File: rtl/lane_sub_pkg.sv
package lane_sub_pkg;

  localparam int unsigned SIMD_W     = 64;
  localparam int unsigned MIN_LANE_W = 8;
  localparam int unsigned NUM_SIZES  = $clog2(SIMD_W / MIN_LANE_W) + 1;
  localparam int unsigned SIZE_IDX_W = $clog2(NUM_SIZES);

  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_SSAT = 2'd1,
    MODE_USAT = 2'd2
  } sat_mode_e;

  typedef struct packed {
    logic                  known;
    logic                  needs_wide;
    logic [SIZE_IDX_W-1:0] size_idx;
    sat_mode_e             mode;
  } op_dec_t;

endpackage

// File: rtl/lane_sub_decode.sv
module lane_sub_decode
  import lane_sub_pkg::*;
(
  input  logic [7:0] op_code,
  output op_dec_t    dec
);

  always_comb begin
    dec            = '0;
    dec.mode       = MODE_WRAP;
    dec.known      = 1'b1;
    unique case (op_code)
      8'hF8: dec.size_idx = SIZE_IDX_W'(0);
      8'hF9: dec.size_idx = SIZE_IDX_W'(1);
      8'hFA: dec.size_idx = SIZE_IDX_W'(2);
      8'hFB: begin
        dec.size_idx   = SIZE_IDX_W'(3);
        dec.needs_wide = 1'b1;
      end
      8'hE8: begin dec.size_idx = SIZE_IDX_W'(0); dec.mode = MODE_SSAT; end
      8'hE9: begin dec.size_idx = SIZE_IDX_W'(1); dec.mode = MODE_SSAT; end
      8'hD8: begin dec.size_idx = SIZE_IDX_W'(0); dec.mode = MODE_USAT; end
      8'hD9: begin dec.size_idx = SIZE_IDX_W'(1); dec.mode = MODE_USAT; end
      default: dec.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/lane_sub_lane.sv
module lane_sub_lane
  import lane_sub_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  sat_mode_e         mode,
  output logic [LANE_W-1:0] y
);

  localparam int unsigned MSB = LANE_W - 1;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [LANE_W:0]   diff;
  logic [LANE_W-1:0] wrap;
  logic              borrow;
  logic              s_ovf;

  always_comb begin
    diff   = {1'b0, a} - {1'b0, b};
    wrap   = diff[LANE_W-1:0];
    borrow = diff[LANE_W];
    // operand signs differ and the result sign left the minuend's sign
    s_ovf  = (a[MSB] ^ b[MSB]) & (wrap[MSB] ^ a[MSB]);
    unique case (mode)
      MODE_SSAT: y = s_ovf ? (a[MSB] ? SMIN : SMAX) : wrap;
      MODE_USAT: y = borrow ? '0 : wrap;
      default:   y = wrap;
    endcase
  end

endmodule

// File: rtl/lane_sub_datapath.sv
module lane_sub_datapath
  import lane_sub_pkg::*;
(
  input  logic [SIMD_W-1:0]     a,
  input  logic [SIMD_W-1:0]     b,
  input  logic [SIZE_IDX_W-1:0] size_idx,
  input  sat_mode_e             mode,
  output logic [SIMD_W-1:0]     y
);

  logic [SIMD_W-1:0] res_by_size [NUM_SIZES];

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    localparam int unsigned LW = MIN_LANE_W << gs;
    localparam int unsigned NL = SIMD_W / LW;
    logic [SIMD_W-1:0] packed_y;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      lane_sub_lane #(.LANE_W(LW)) u_lane (
        .a    (a[gl*LW +: LW]),
        .b    (b[gl*LW +: LW]),
        .mode (mode),
        .y    (packed_y[gl*LW +: LW])
      );
    end
    assign res_by_size[gs] = packed_y;
  end

  assign y = res_by_size[size_idx];

endmodule

// File: rtl/lane_sub_unit.sv
module lane_sub_unit
  import lane_sub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        op_code,
  input  logic [SIMD_W-1:0] src_a,
  input  logic [SIMD_W-1:0] src_b,
  input  logic              ctl_emulate,
  input  logic              ctl_task_sw,
  input  logic              feat_base,
  input  logic              feat_wide,
  output logic [SIMD_W-1:0] res_q,
  output logic              out_valid,
  output logic              undef_op,
  output logic              fault_invalid,
  output logic              fault_navail
);

  op_dec_t           dec;
  logic [SIMD_W-1:0] dp_y;
  logic              refuse;
  logic              res_en;
  logic [SIMD_W-1:0] res_d;
  logic              valid_d, undef_d, inv_d, nav_d;

  lane_sub_decode u_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  lane_sub_datapath u_dp (
    .a        (src_a),
    .b        (src_b),
    .size_idx (dec.size_idx),
    .mode     (dec.mode),
    .y        (dp_y)
  );

  // next state
  always_comb begin
    refuse  = ctl_emulate | (dec.needs_wide ? ~feat_wide : ~feat_base);
    valid_d = in_valid;
    undef_d = in_valid & ~dec.known;
    inv_d   = in_valid & dec.known & refuse;
    nav_d   = in_valid & dec.known & ~refuse & ctl_task_sw;
    res_en  = in_valid & dec.known & ~refuse & ~ctl_task_sw;
    res_d   = dp_y;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      undef_op      <= 1'b0;
      fault_invalid <= 1'b0;
      fault_navail  <= 1'b0;
    end else begin
      out_valid     <= valid_d;
      undef_op      <= undef_d;
      fault_invalid <= inv_d;
      fault_navail  <= nav_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(res_q)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(undef_op || fault_invalid || fault_navail)); // R4
  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_op, fault_invalid, fault_navail})); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_op || fault_invalid || fault_navail) |-> $stable(res_q)); // R5
  AST_EMULATE_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.known && ctl_emulate) |=> fault_invalid); // R6

endmodule

// File: tb/lane_sub_unit_tb_top.sv
`timescale 1ns/1ps
module lane_sub_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  op_code;
  logic [63:0] src_a, src_b;
  logic        ctl_emulate, ctl_task_sw, feat_base, feat_wide;
  logic [63:0] res_q;
  logic        out_valid, undef_op, fault_invalid, fault_navail;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [63:0] model_res;

  always #2 clk = ~clk;

  lane_sub_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .ctl_emulate(ctl_emulate),
    .ctl_task_sw(ctl_task_sw), .feat_base(feat_base), .feat_wide(feat_wide),
    .res_q(res_q), .out_valid(out_valid), .undef_op(undef_op),
    .fault_invalid(fault_invalid), .fault_navail(fault_navail)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [7:0] op);
    return op inside {8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hE8, 8'hE9, 8'hD8, 8'hD9};
  endfunction

  function automatic logic [63:0] ref_sub(input logic [7:0] op,
                                          input logic [63:0] a, input logic [63:0] b);
    int lw;
    int md; // 0 wrap, 1 signed sat, 2 unsigned sat
    logic [63:0] r, m, ua, ub, lr;
    logic signed [65:0] sa, sb, sd, smax, smin;
    case (op)
      8'hF8: begin lw = 8;  md = 0; end
      8'hF9: begin lw = 16; md = 0; end
      8'hFA: begin lw = 32; md = 0; end
      8'hFB: begin lw = 64; md = 0; end
      8'hE8: begin lw = 8;  md = 1; end
      8'hE9: begin lw = 16; md = 1; end
      8'hD8: begin lw = 8;  md = 2; end
      default: begin lw = 16; md = 2; end
    endcase
    m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    r = '0;
    for (int k = 0; k < 64 / lw; k++) begin
      ua = (a >> (k * lw)) & m;
      ub = (b >> (k * lw)) & m;
      lr = (ua - ub) & m;
      if (md == 1) begin
        sa = ua[lw-1] ? $signed({2'b0, ua}) - (66'sd1 <<< lw) : $signed({2'b0, ua});
        sb = ub[lw-1] ? $signed({2'b0, ub}) - (66'sd1 <<< lw) : $signed({2'b0, ub});
        sd = sa - sb;
        smax = (66'sd1 <<< (lw - 1)) - 66'sd1;
        smin = -(66'sd1 <<< (lw - 1));
        if (sd > smax) sd = smax;
        if (sd < smin) sd = smin;
        lr = sd[63:0] & m;
      end else if (md == 2) begin
        if (ub > ua) lr = '0;
      end
      r |= lr << (k * lw);
    end
    return r;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                        input bit emu, input bit ts, input bit fb, input bit fw,
                        input string req);
    bit known, refuse;
    bit e_und, e_inv, e_nav;
    @(negedge clk);
    in_valid = 1'b1; op_code = op; src_a = a; src_b = b;
    ctl_emulate = emu; ctl_task_sw = ts; feat_base = fb; feat_wide = fw;
    known  = is_known(op);
    refuse = emu || ((op == 8'hFB) ? !fw : !fb);
    e_und  = !known;
    e_inv  = known && refuse;
    e_nav  = known && !refuse && ts;
    if (known && !refuse && !ts) model_res = ref_sub(op, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " out_valid"}, 64'(out_valid), 64'd1);
    chk(undef_op === e_und, {req, " undef_op"}, 64'(undef_op), 64'(e_und));
    chk(fault_invalid === e_inv, {req, " fault_invalid"}, 64'(fault_invalid), 64'(e_inv));
    chk(fault_navail === e_nav, {req, " fault_navail"}, 64'(fault_navail), 64'(e_nav));
    chk(res_q === model_res, {req, " res_q"}, res_q, model_res);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(out_valid === 1'b0 && !undef_op && !fault_invalid && !fault_navail,
        "R4 idle flags", {60'd0, out_valid, undef_op, fault_invalid, fault_navail}, 64'd0);
    chk(res_q === model_res, "R4 idle hold", res_q, model_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [8];
    ops = '{8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hE8, 8'hE9, 8'hD8, 8'hD9};
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; src_a = '0; src_b = '0;
    ctl_emulate = 0; ctl_task_sw = 0; feat_base = 1; feat_wide = 1;
    model_res = '0;
    repeat (3) @(negedge clk);
    chk(res_q === 64'd0 && !out_valid && !undef_op && !fault_invalid && !fault_navail,
        "R8 reset state", res_q, 64'd0);
    rst_n = 1'b1;
    idle_check();

    // directed corners
    run_op(8'hF8, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 0, 0, 1, 1, "R1 byte wrap no borrow leak");
    chk(res_q === 64'h0000_0000_0000_01FF, "R1 byte wrap value", res_q, 64'h0000_0000_0000_01FF);
    run_op(8'hFB, 64'd0, 64'd1, 0, 0, 1, 1, "R1 64-bit wrap");
    chk(res_q === '1, "R1 64-bit all ones", res_q, '1);
    run_op(8'hF9, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001, 0, 0, 1, 1, "R1 word wrap");
    run_op(8'hFA, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 0, 0, 1, 1, "R1 dword wrap");
    run_op(8'hE8, 64'h0000_0000_0000_807F, 64'h0000_0000_0000_0180, 0, 0, 1, 1, "R2 byte signed clamp");
    chk(res_q === 64'h0000_0000_0000_807F, "R2 byte clamp values", res_q, 64'h0000_0000_0000_807F);
    run_op(8'hE9, 64'h0000_0000_7FFF_8000, 64'h0000_0000_FFFF_0001, 0, 0, 1, 1, "R2 word signed clamp");
    chk(res_q === 64'h0000_0000_7FFF_8000, "R2 word clamp values", res_q, 64'h0000_0000_7FFF_8000);
    run_op(8'hD8, 64'h0000_0000_0000_0510, 64'h0000_0000_0000_0601, 0, 0, 1, 1, "R3 byte unsigned floor");
    chk(res_q === 64'h0000_0000_0000_000F, "R3 byte floor values", res_q, 64'h0000_0000_0000_000F);
    run_op(8'hD9, 64'h0001_FFFF_0000_1234, 64'h0002_0001_0000_1234, 0, 0, 1, 1, "R3 word unsigned floor");
    idle_check();
    run_op(8'h00, '1, 64'd5, 0, 0, 1, 1, "R5 undefined code");
    run_op(8'hFC, '1, 64'd5, 0, 0, 1, 1, "R5 undefined neighbour code");
    run_op(8'hF8, '1, 64'd5, 1, 0, 1, 1, "R6 emulate set");
    run_op(8'hF8, '1, 64'd5, 0, 0, 0, 1, "R6 base feature low");
    run_op(8'hFB, '1, 64'd5, 0, 0, 1, 0, "R6 wide feature low");
    run_op(8'hF8, '1, 64'd5, 0, 0, 1, 0, "R6 wide feature low narrow ok");
    run_op(8'hFB, '1, 64'd5, 0, 0, 0, 1, "R6 base feature low wide ok");
    run_op(8'hE9, 64'd9, 64'd5, 0, 1, 1, 1, "R7 task switched");
    run_op(8'hD8, 64'd9, 64'd5, 1, 1, 1, 1, "R7 invalid over navail");
    idle_check();

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [63:0] a, b;
      bit emu, ts, fb, fw;
      op = ($urandom % 10 == 0) ? 8'($urandom) : ops[$urandom % 8];
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      if ($urandom % 4 == 0) b = a ^ 64'(1 << ($urandom % 64));
      emu = ($urandom % 12 == 0);
      ts  = ($urandom % 12 == 0);
      fb  = ($urandom % 12 != 0);
      fw  = ($urandom % 12 != 0);
      run_op(op, a, b, emu, ts, fb, fw, "R1 R2 R3 R5 R6 R7 random");
      if (i % 50 == 0) idle_check();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule